// File: doc/BRIEF.md
# Multi-sector transfer sequencer

This block moves a run of card sectors between a memory buffer and a memory card by driving two lower engines: a command engine that issues one card command and collects its response, and a block data engine that streams whole sectors between the card data lines and the buffer. A request carries a direction, a buffer address, a first sector number and a sector count. The sequencer cuts the request into chunks of at most `MAX_CHUNK` blocks. For each chunk it issues a multiple-block command, runs the data engine and closes the chunk with a stop-transmission command.

Cards that address by byte get sector numbers scaled by the sector size; cards that address by block get them unchanged. The order of the two engines depends on direction. On a read the data engine is armed before the read command, so no incoming block is missed. On a write the write command must be accepted before any data is sent. Any command or data failure, and a data phase that outlasts the millisecond timeout, ends the request with an error.

Both engines share one handshake. The engine raises busy in the cycle after its start pulse and holds it until the operation ends. Its error output is read in the first cycle that busy is low again.

Top module: `sector_xfer_seq`

## Requirements
- R1: A request whose count is zero, or that arrives while `card_ready` is low, issues no command and no data start; `done` and `err` are both high in the cycle after the request.
- R2: Each chunk moves min(remaining, `MAX_CHUNK`) blocks. At every data start, `dat_blocks` carries that size minus one and `dat_flush` is high.
- R3: With `card_block` low, the command argument is the first sector times `SECTOR_BYTES`, and it grows by blocks×`SECTOR_BYTES` per chunk. With `card_block` high, it is the sector itself and grows by the block count.
- R4: `dat_addr` starts at the request address and grows by blocks×`SECTOR_BYTES` after each chunk.
- R5: On a read (`req_write`=0), `dat_start` comes first and is followed in the next cycle by `cmd_start` with index 18. If that command reports an error, `dat_stop` pulses and the request ends with `err`, with no stop-transmission command.
- R6: On a write (`req_write`=1), command 25 is issued first, and `dat_start` follows only after that command has completed without error. If command 25 fails, the request ends with `err` and has no data start and no stop-transmission command.
- R7: After every chunk's data phase, successful or not, command 12 is issued with argument 0 and `cmd_wait_busy` high.
- R8: A data engine error pulses `dat_stop`, is followed by command 12, and ends the request with `err`.
- R9: If the data engine is still busy after `TIMEOUT_MS` pulses of `ms_tick`, counted from the start of the data wait, `dat_stop` pulses, command 12 follows, and the request ends with `err`.
- R10: `done` is a one-cycle pulse. On success it comes with `err` low, and only after the last chunk's command 12 has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request pulse, accepted while idle |
| req_write | input | 1 | 1 = buffer to card, 0 = card to buffer |
| req_addr | input | ADDR_W | Buffer byte address |
| req_sector | input | SECT_W | First sector number |
| req_count | input | CNT_W | Number of sectors |
| card_ready | input | 1 | Card has been brought up |
| card_block | input | 1 | Card addresses by block (1) or by byte (0) |
| ms_tick | input | 1 | One pulse per millisecond |
| done | output | 1 | Request finished (one cycle) |
| err | output | 1 | Qualifies `done`: request failed |
| cmd_start | output | 1 | Issue a command |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_wait_busy | output | 1 | Response type with busy wait on the data line |
| cmd_busy | input | 1 | Command engine working |
| cmd_error | input | 1 | Last command failed |
| dat_start | output | 1 | Arm the data engine |
| dat_stop | output | 1 | Abort the data engine and its buffer transfer |
| dat_flush | output | 1 | Empty the data FIFO on start |
| dat_write | output | 1 | Data direction, 1 = to card |
| dat_blocks | output | BLK_W | Chunk size minus one |
| dat_addr | output | ADDR_W | Buffer address of the chunk |
| dat_busy | input | 1 | Data engine working |
| dat_error | input | 1 | Last data transfer failed |

## Verification
Assertions check the following on every cycle: rejected requests finish at once with an error; a read data start is followed directly by command 18; a write data start never overlaps a busy command; `done` never lasts two cycles or lands while a command is running; and the timeout counter stays within its limit. Chunk sizes, scaled sector arguments, address strides and the full event order per chunk can only be shown by the bench scenarios. The bench sweeps counts across chunk boundaries for both directions and both addressing kinds. The error and timeout paths are shown by injecting faults into the engine models.

// File: rtl/sector_xfer_seq.sv
module sector_xfer_seq #(
  parameter int ADDR_W       = 32,
  parameter int SECT_W       = 32,
  parameter int CNT_W        = 32,
  parameter int MAX_CHUNK    = 256,
  parameter int SECTOR_BYTES = 512,
  parameter int TIMEOUT_MS   = 5000,
  localparam int BLK_W       = (MAX_CHUNK > 1) ? $clog2(MAX_CHUNK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SECT_W-1:0] req_sector,
  input  logic [CNT_W-1:0]  req_count,
  input  logic              card_ready,
  input  logic              card_block,
  input  logic              ms_tick,
  output logic              done,
  output logic              err,
  output logic              cmd_start,
  output logic [5:0]        cmd_index,
  output logic [31:0]       cmd_arg,
  output logic              cmd_wait_busy,
  input  logic              cmd_busy,
  input  logic              cmd_error,
  output logic              dat_start,
  output logic              dat_stop,
  output logic              dat_flush,
  output logic              dat_write,
  output logic [BLK_W-1:0]  dat_blocks,
  output logic [ADDR_W-1:0] dat_addr,
  input  logic              dat_busy,
  input  logic              dat_error
);
  localparam int SHIFT = $clog2(SECTOR_BYTES);
  localparam int TMO_W = $clog2(TIMEOUT_MS + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ARM, S_CMD, S_CMDW, S_DATW, S_ABORT, S_STOP, S_STOPW, S_FIN
  } state_t;

  state_t            state;
  logic              wr, blk, fail, gap, skip12;
  logic [ADDR_W-1:0] addr;
  logic [SECT_W-1:0] sector;
  logic [CNT_W-1:0]  rem, chunk;
  logic [TMO_W-1:0]  tcnt;
  logic              tmo;

  assign chunk = (rem > CNT_W'(MAX_CHUNK)) ? CNT_W'(MAX_CHUNK) : rem;
  assign tmo   = (tcnt == TMO_W'(TIMEOUT_MS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wr     <= 1'b0;
      blk    <= 1'b0;
      fail   <= 1'b0;
      gap    <= 1'b0;
      skip12 <= 1'b0;
      addr   <= '0;
      sector <= '0;
      rem    <= '0;
      tcnt   <= '0;
    end else begin
      tcnt <= (state != S_DATW) ? '0 : (ms_tick && !tmo) ? tcnt + 1'b1 : tcnt;
      case (state)
        S_IDLE: if (req_valid) begin
          wr     <= req_write;
          blk    <= card_block;
          addr   <= req_addr;
          rem    <= req_count;
          sector <= card_block ? req_sector : req_sector << SHIFT;
          skip12 <= 1'b0;
          if (req_count == '0 || !card_ready) begin
            fail  <= 1'b1;
            state <= S_FIN;
          end else begin
            fail  <= 1'b0;
            state <= req_write ? S_CMD : S_ARM;
          end
        end
        S_ARM: begin
          gap   <= 1'b1;
          state <= wr ? S_DATW : S_CMD;
        end
        S_CMD: begin
          gap   <= 1'b1;
          state <= S_CMDW;
        end
        S_CMDW: begin
          gap <= 1'b0;
          if (!gap && !cmd_busy) begin
            if (cmd_error) begin
              fail   <= 1'b1;
              skip12 <= 1'b1;
              state  <= wr ? S_FIN : S_ABORT;
            end else begin
              state  <= wr ? S_ARM : S_DATW;
            end
          end
        end
        S_DATW: begin
          gap <= 1'b0;
          if (!gap && !dat_busy) begin
            fail  <= dat_error;
            state <= dat_error ? S_ABORT : S_STOP;
          end else if (tmo) begin
            fail  <= 1'b1;
            state <= S_ABORT;
          end
        end
        S_ABORT: state <= skip12 ? S_FIN : S_STOP;
        S_STOP: begin
          gap   <= 1'b1;
          state <= S_STOPW;
        end
        S_STOPW: begin
          gap <= 1'b0;
          if (!gap && !cmd_busy) begin
            if (fail || rem == chunk) begin
              state <= S_FIN;
            end else begin
              state <= wr ? S_CMD : S_ARM;
            end
            addr   <= addr + (ADDR_W'(chunk) << SHIFT);
            sector <= sector + (blk ? SECT_W'(chunk) : SECT_W'(chunk) << SHIFT);
            rem    <= rem - chunk;
          end
        end
        S_FIN:   state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign done          = (state == S_FIN);
  assign err           = done && fail;
  assign cmd_start     = (state == S_CMD) || (state == S_STOP);
  assign cmd_wait_busy = (state == S_STOP);
  assign cmd_index     = (state == S_STOP) ? 6'd12 : (wr ? 6'd25 : 6'd18);
  assign cmd_arg       = (state == S_STOP) ? 32'd0 : 32'(sector);
  assign dat_start     = (state == S_ARM);
  assign dat_flush     = dat_start;
  assign dat_stop      = (state == S_ABORT);
  assign dat_write     = wr;
  assign dat_addr      = addr;
  assign dat_blocks    = BLK_W'(chunk - 1'b1);

  AST_REJECT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req_valid && (req_count == '0 || !card_ready)) |=> (done && err)); // R1
  AST_READ_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_start && !dat_write) |=> (cmd_start && cmd_index == 6'd18)); // R5
  AST_WRITE_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_start && dat_write) |-> !cmd_busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !cmd_busy); // R10
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt <= TMO_W'(TIMEOUT_MS)); // R9
endmodule

// File: tb/sector_xfer_seq_tb.sv
module sector_xfer_seq_tb;
  localparam int MAXC = 4;
  localparam int TMO  = 3;
  localparam int BW   = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, card_ready = 1'b0, card_block = 1'b0;
  logic [31:0] req_addr = '0, req_sector = '0, req_count = '0;
  logic ms_tick = 1'b0;
  logic done, err, cmd_start, cmd_wait_busy, dat_start, dat_stop, dat_flush, dat_write;
  logic [5:0] cmd_index;
  logic [31:0] cmd_arg, dat_addr;
  logic [BW-1:0] dat_blocks;
  logic cmd_busy = 1'b0, cmd_error = 1'b0, dat_busy = 1'b0, dat_error = 1'b0;

  always #2 clk = ~clk;

  sector_xfer_seq #(.MAX_CHUNK(MAXC), .TIMEOUT_MS(TMO)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_sector(req_sector), .req_count(req_count),
    .card_ready(card_ready), .card_block(card_block), .ms_tick(ms_tick),
    .done(done), .err(err), .cmd_start(cmd_start), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .cmd_wait_busy(cmd_wait_busy), .cmd_busy(cmd_busy),
    .cmd_error(cmd_error), .dat_start(dat_start), .dat_stop(dat_stop),
    .dat_flush(dat_flush), .dat_write(dat_write), .dat_blocks(dat_blocks),
    .dat_addr(dat_addr), .dat_busy(dat_busy), .dat_error(dat_error));

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  int cyc = 0;
  logic [81:0] got [0:31];
  int gcyc [0:31];
  int ng = 0;
  logic [81:0] exp_ev [0:31];
  int ne = 0;
  int fail_idx = -1;
  bit dat_fail = 1'b0, dat_hang = 1'b0;
  int ccnt = 0, dcnt = 0;
  logic [5:0] cur_idx = '0;

  function automatic logic [81:0] ev(int k, int idx, logic [31:0] arg, int blocks,
                                     bit w, bit f, logic [31:0] a);
    return {2'(k), 6'(idx), arg, a, 8'(blocks), w, f};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ms_tick <= (cyc % 4 == 3);
    if (cmd_start) begin
      got[ng] = ev(0, int'(cmd_index), cmd_arg, 0, 1'b0, cmd_wait_busy, 32'd0);
      gcyc[ng] = cyc; ng = ng + 1;
      cmd_busy <= 1'b1; cmd_error <= 1'b0; ccnt = 2; cur_idx = cmd_index;
    end else if (cmd_busy) begin
      if (ccnt == 0) begin
        cmd_busy <= 1'b0; cmd_error <= (int'(cur_idx) == fail_idx);
      end else ccnt = ccnt - 1;
    end
    if (dat_stop) begin
      got[ng] = ev(2, 0, 32'd0, 0, 1'b0, 1'b0, 32'd0);
      gcyc[ng] = cyc; ng = ng + 1;
      dat_busy <= 1'b0;
    end else if (dat_start) begin
      got[ng] = ev(1, 0, 32'd0, int'(dat_blocks), dat_write, dat_flush, dat_addr);
      gcyc[ng] = cyc; ng = ng + 1;
      dat_busy <= 1'b1; dat_error <= 1'b0; dcnt = 3;
    end else if (dat_busy && !dat_hang) begin
      if (dcnt == 0) begin
        dat_busy <= 1'b0; dat_error <= dat_fail;
      end else dcnt = dcnt - 1;
    end
  end

  task automatic chk(bit ok, string tag, logic [81:0] act, logic [81:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic add(logic [81:0] e);
    exp_ev[ne] = e; ne++;
  endtask

  task automatic build(bit w, logic [31:0] a, logic [31:0] s, int n, bit blk);
    logic [31:0] sec = blk ? s : s * 512;
    int rem = n;
    ne = 0;
    while (rem > 0) begin
      int c = (rem > MAXC) ? MAXC : rem;
      if (!w) begin
        add(ev(1, 0, 0, c - 1, 1'b0, 1'b1, a)); add(ev(0, 18, sec, 0, 1'b0, 1'b0, 0));
      end else begin
        add(ev(0, 25, sec, 0, 1'b0, 1'b0, 0)); add(ev(1, 0, 0, c - 1, 1'b1, 1'b1, a));
      end
      add(ev(0, 12, 0, 0, 1'b0, 1'b1, 0));
      a = a + 32'(c * 512);
      sec = sec + (blk ? 32'(c) : 32'(c * 512));
      rem -= c;
    end
  endtask

  function automatic string tag_of(logic [81:0] e);
    if (e[81:80] == 2'd1) return "R2/R4 data start";
    if (e[81:80] == 2'd2) return "R8 data stop";
    if (e[79:74] == 6'd12) return "R7 stop command";
    if (e[79:74] == 6'd18) return "R5 read command (R3 arg)";
    return "R6 write command (R3 arg)";
  endfunction

  task automatic run(bit w, logic [31:0] a, logic [31:0] s, int n, bit blk, bit rdy,
                     bit exp_err, string tag);
    int guard = 0;
    @(negedge clk);
    ng = 0;
    req_write = w; req_addr = a; req_sector = s; req_count = 32'(n);
    card_block = blk; card_ready = rdy; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk(done === 1'b1, {tag, " done seen"}, 82'(done), 82'd1);
    chk(err === exp_err, {"R10 err with done, ", tag}, 82'(err), 82'(exp_err));
    chk(cmd_busy === 1'b0, "R10 done after last command", 82'(cmd_busy), 82'd0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", 82'(done), 82'd0);
    chk(ng == ne, {tag, " event count"}, 82'(ng), 82'(ne));
    for (int i = 0; i < ne && i < ng; i++)
      chk(got[i] === exp_ev[i], tag_of(exp_ev[i]), got[i], exp_ev[i]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && cmd_start === 1'b0 && dat_start === 1'b0,
        "R10 reset quiet", 82'({done, cmd_start, dat_start}), 82'd0);
    rst_n = 1'b1;
    @(negedge clk);

    ne = 0;
    run(1'b0, 32'h100, 32'd7, 0, 1'b1, 1'b1, 1'b1, "R1 zero count");
    ne = 0;
    run(1'b1, 32'h100, 32'd7, 3, 1'b0, 1'b0, 1'b1, "R1 card not ready");

    for (int w = 0; w < 2; w++)
      for (int blk = 0; blk < 2; blk++)
        for (int n = 1; n <= 9; n++) begin
          logic [31:0] a = 32'h4000 + 32'(n * 16);
          logic [31:0] s = 32'(3 + n + 100 * blk);
          build(w[0], a, s, n, blk[0]);
          run(w[0], a, s, n, blk[0], 1'b1, 1'b0, "R2 R3 R4 sweep");
        end

    fail_idx = 18; ne = 0;
    add(ev(1, 0, 0, 1, 1'b0, 1'b1, 32'h800)); add(ev(0, 18, 32'd10 * 512, 0, 1'b0, 1'b0, 0));
    add(ev(2, 0, 0, 0, 1'b0, 1'b0, 0));
    run(1'b0, 32'h800, 32'd10, 2, 1'b0, 1'b1, 1'b1, "R5 read command error");

    fail_idx = 25; ne = 0;
    add(ev(0, 25, 32'd10, 0, 1'b0, 1'b0, 0));
    run(1'b1, 32'h800, 32'd10, 6, 1'b1, 1'b1, 1'b1, "R6 write command error");
    fail_idx = -1;

    dat_fail = 1'b1; ne = 0;
    add(ev(1, 0, 0, 3, 1'b0, 1'b1, 32'h900)); add(ev(0, 18, 32'd20, 0, 1'b0, 1'b0, 0));
    add(ev(2, 0, 0, 0, 1'b0, 1'b0, 0)); add(ev(0, 12, 0, 0, 1'b0, 1'b1, 0));
    run(1'b0, 32'h900, 32'd20, 5, 1'b1, 1'b1, 1'b1, "R8 data error");
    dat_fail = 1'b0;

    dat_hang = 1'b1; ne = 0;
    add(ev(0, 25, 32'd4 * 512, 0, 1'b0, 1'b0, 0)); add(ev(1, 0, 0, 0, 1'b1, 1'b1, 32'hA00));
    add(ev(2, 0, 0, 0, 1'b0, 1'b0, 0)); add(ev(0, 12, 0, 0, 1'b0, 1'b1, 0));
    run(1'b1, 32'hA00, 32'd4, 1, 1'b0, 1'b1, 1'b1, "R9 data timeout");
    chk(ng >= 3 && (gcyc[2] - gcyc[1]) >= 9 && (gcyc[2] - gcyc[1]) <= 18,
        "R9 timeout window", 82'(gcyc[2] - gcyc[1]), 82'(TMO * 4));
    dat_hang = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(4 * 190000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule